// File: doc/BRIEF.md
# Posted Write Clock-Domain Synchronizer

This block is the bus-side write path of a peripheral whose functional logic runs on a slow clock that is unrelated to the bus clock. Ten registers are mirrored into the functional domain. A bus write to one of them is stored on the bus side and then carried across by a toggle handshake. A per-register pending flag stays set until the functional side has captured the value and its acknowledge has come back. Software reads these flags as a bitmap and polls its bit before touching that register again.

Write completion can be switched at run time. In posted mode, which is the reset default, a write completes on the bus in the cycle it is presented, provided its pending flag is clear. In non-posted mode the bus is stalled until the acknowledge returns. Any further access to a register whose flag is still set is held off with ready low until the flag clears. Other addresses are written directly and are not tracked.

Top module: `posted_write_sync`

## Requirements
- R1: After reset the pending bitmap reads 0, the interface-control register reads 0x4 (posted mode on), and every functional-domain value and update strobe is 0.
- R2: The tracked registers and their pending bit positions are: 0x24→0, 0x28→1, 0x2C→2, 0x30→3, 0x38→4, 0x48→5, 0x4C→6, 0x50→7, 0x54→8, 0x58→9. A write to each of them sets only its own bit.
- R3: In posted mode, a write to a tracked register whose bit is clear completes in its first cycle, with ready high. Its pending bit reads 1 from the next cycle.
- R4: Reading offset 0x34 returns the pending bitmap in bits 9:0, with the upper bits zero. A bit clears by itself once the functional side has taken the value.
- R5: The written value appears on that register's functional output, together with a one-functional-cycle update strobe, no later than the 4th rising functional clock edge after the bus write completes.
- R6: A read or write to a tracked register whose pending bit is set keeps ready low until the bit clears. A second write then delivers its own value.
- R7: A write to an untracked address completes in its first cycle, sets no pending bit and changes no functional output.
- R8: Bit 2 of the interface-control register at 0x40 selects posted mode. With it at 0, a tracked write keeps ready low until the acknowledge returns. At completion the bit is already clear and the functional value is already updated.
- R9: A read of a tracked register returns the value last written to it.
- R10: Pending bits of different registers run independently. A functional output changes only together with an update strobe, and only in its own slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus-domain asynchronous reset, active low |
| fclk | input | 1 | Functional clock |
| frst_n | input | 1 | Functional-domain asynchronous reset, active low |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset of the access |
| bus_wdata | input | DW | Write data |
| bus_ready | output | 1 | Access completes in this cycle |
| bus_rdata | output | DW | Read data, valid while ready is high |
| f_regs | output | 10*DW | Functional-domain copies; slice i belongs to pending bit i |
| f_update | output | 10 | One-functional-cycle strobe per register when its copy changes |

## Verification
A wrong toggle or acknowledge state shows up as a pending bit that never clears, or that clears before the functional copy has changed. Either one appears in the bitmap read or in a bus stall that lasts too long, within a few functional clock periods of the write. A broken address decode moves the wrong bit in the bitmap, or lets an untracked write alter a functional slice, on the very next bitmap read. A mode error shows at once: either a non-posted write that returns with its bit still set, or a posted write that stalls.

// File: rtl/posted_write_sync.sv
module posted_write_sync #(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fclk,
  input  logic             frst_n,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic             bus_ready,
  output logic [DW-1:0]    bus_rdata,
  output logic [10*DW-1:0] f_regs,
  output logic [9:0]       f_update
);
  localparam int NREG = 10;
  localparam int IW   = $clog2(NREG);
  localparam logic [AW-1:0] PEND_ADDR = AW'('h34);
  localparam logic [AW-1:0] IFC_ADDR  = AW'('h40);
  localparam int POST_BIT = 2;

  logic [NREG-1:0][DW-1:0] bdata, fdata;
  logic [NREG-1:0] btog, ack_s1, ack_s2, pend;
  logic [NREG-1:0] f_s1, f_s2, fseen;
  logic            posted, np_wait, hit, launch;
  logic [IW-1:0]   idx;

  always_comb begin
    hit = 1'b1;
    idx = '0;
    case (bus_addr)
      AW'('h24): idx = IW'(0);
      AW'('h28): idx = IW'(1);
      AW'('h2c): idx = IW'(2);
      AW'('h30): idx = IW'(3);
      AW'('h38): idx = IW'(4);
      AW'('h48): idx = IW'(5);
      AW'('h4c): idx = IW'(6);
      AW'('h50): idx = IW'(7);
      AW'('h54): idx = IW'(8);
      AW'('h58): idx = IW'(9);
      default:   hit = 1'b0;
    endcase
  end

  assign pend = btog ^ ack_s2;

  always_comb begin
    if (hit && pend[idx])
      bus_ready = 1'b0;
    else if (hit && bus_write && !posted)
      bus_ready = np_wait;
    else
      bus_ready = 1'b1;
  end

  assign launch = bus_valid && bus_write && hit && !pend[idx] && (posted || !np_wait);

  always_comb begin
    if (bus_addr == PEND_ADDR)
      bus_rdata = DW'(pend);
    else if (bus_addr == IFC_ADDR)
      bus_rdata = DW'({posted, {POST_BIT{1'b0}}});
    else if (hit)
      bus_rdata = bdata[idx];
    else
      bus_rdata = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bdata   <= '0;
      btog    <= '0;
      ack_s1  <= '0;
      ack_s2  <= '0;
      posted  <= 1'b1;
      np_wait <= 1'b0;
    end else begin
      ack_s1 <= fseen;
      ack_s2 <= ack_s1;
      if (launch) begin
        btog[idx]  <= ~btog[idx];
        bdata[idx] <= bus_wdata;
      end
      if (launch && !posted)
        np_wait <= 1'b1;
      else if (bus_valid && bus_ready)
        np_wait <= 1'b0;
      if (bus_valid && bus_write && bus_addr == IFC_ADDR)
        posted <= bus_wdata[POST_BIT];
    end
  end

  always_ff @(posedge fclk or negedge frst_n) begin
    if (!frst_n) begin
      f_s1     <= '0;
      f_s2     <= '0;
      fseen    <= '0;
      fdata    <= '0;
      f_update <= '0;
    end else begin
      f_s1 <= btog;
      f_s2 <= f_s1;
      for (int i = 0; i < NREG; i++) begin
        f_update[i] <= f_s2[i] ^ fseen[i];
        if (f_s2[i] != fseen[i]) begin
          fseen[i] <= f_s2[i];
          fdata[i] <= bdata[i];
        end
      end
    end
  end

  assign f_regs = fdata;
endmodule

module posted_write_sync_chk #(
  parameter int DW   = 32,
  parameter int NREG = 10,
  parameter int IW   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fclk,
  input logic               frst_n,
  input logic               bus_valid,
  input logic               bus_write,
  input logic               bus_ready,
  input logic               hit,
  input logic [IW-1:0]      idx,
  input logic [NREG-1:0]    pend,
  input logic               posted,
  input logic [NREG*DW-1:0] f_regs,
  input logic [NREG-1:0]    f_update
);
  AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && hit && pend[idx] |-> !bus_ready); // R6
  AST_UNTRACKED_READY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !hit |-> bus_ready); // R7
  AST_POSTED_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ready && bus_write && hit && posted |=> pend[$past(idx)]); // R3
  AST_NONPOSTED_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ready && bus_write && hit && !posted |-> !pend[idx]); // R8
  AST_FDATA_WITH_STROBE: assert property (@(posedge fclk) disable iff (!frst_n)
    !$stable(f_regs) |-> f_update != '0); // R10
endmodule

bind posted_write_sync posted_write_sync_chk #(.DW(DW), .NREG(NREG), .IW(IW)) i_chk (
  .clk(clk), .rst_n(rst_n), .fclk(fclk), .frst_n(frst_n),
  .bus_valid(bus_valid), .bus_write(bus_write), .bus_ready(bus_ready),
  .hit(hit), .idx(idx), .pend(pend), .posted(posted),
  .f_regs(f_regs), .f_update(f_update)
);

// File: tb/test_posted_write_sync.sv
`timescale 1ns/100ps
module test_posted_write_sync;
  logic clk = 0, fclk = 0, rst_n = 0, frst_n = 0;
  logic bus_valid = 0, bus_write = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic bus_ready;
  logic [31:0] bus_rdata;
  logic [319:0] f_regs;
  logic [9:0] f_update;
  int n_cmp = 0, n_bad = 0;

  posted_write_sync i_posted_write_sync (.*);

  always #5 clk = ~clk;
  initial begin #2.3; forever #18.5 fclk = ~fclk; end

  initial begin
    #500us;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [7:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output int stalls);
    @(negedge clk);
    bus_valid = 1; bus_write = wr; bus_addr = a; bus_wdata = d; stalls = 0;
    forever begin
      #1;
      if (bus_ready) break;
      stalls++;
      @(negedge clk);
    end
    rd = bus_rdata;
    @(posedge clk);
    #1 bus_valid = 0;
  endtask

  function automatic logic [7:0] addr_of(input int i);
    case (i)
      0: return 8'h24; 1: return 8'h28; 2: return 8'h2c; 3: return 8'h30;
      4: return 8'h38; 5: return 8'h48; 6: return 8'h4c; 7: return 8'h50;
      8: return 8'h54; default: return 8'h58;
    endcase
  endfunction

  function automatic logic [31:0] slice(input int i);
    return f_regs[i*32 +: 32];
  endfunction

  task automatic wait_clear(input string req);
    logic [31:0] rd; int s; int polls = 0;
    do begin acc(0, 8'h34, 0, rd, s); polls++; end while (rd != 0 && polls < 200);
    chk(req, rd, 0);
  endtask

  task automatic t_reset;
    logic [31:0] rd; int s;
    acc(0, 8'h34, 0, rd, s); chk("R1 pend", rd, 0);
    acc(0, 8'h40, 0, rd, s); chk("R1 ifctrl", rd, 32'h4);
    chk("R1 fregs", 32'(f_regs != 0), 0);
    chk("R1 fupd", 32'(f_update), 0);
  endtask

  task automatic t_map;
    logic [31:0] rd; int s;
    for (int i = 0; i < 10; i++) begin
      acc(1, addr_of(i), 32'h1000 + i, rd, s);
      acc(0, 8'h34, 0, rd, s);
      chk("R2 bit position", rd, 32'(1) << i);
      wait_clear("R4 clears");
      chk("R2 slice", slice(i), 32'h1000 + i);
    end
  endtask

  task automatic t_posted;
    logic [31:0] rd; int s, cnt;
    logic seen_upd;
    acc(1, 8'h28, 32'hA5A5_0001, rd, s);
    chk("R3 no stall", s, 0);
    cnt = 0; seen_upd = 0;
    while (cnt < 10 && slice(1) != 32'hA5A5_0001) begin
      @(posedge fclk); #1; cnt++;
      if (slice(1) == 32'hA5A5_0001) seen_upd = f_update[1];
    end
    chk("R5 latency ok", 32'(cnt <= 4), 1);
    chk("R5 strobe", 32'(seen_upd), 1);
    @(posedge fclk); #1;
    chk("R5 strobe one cycle", 32'(f_update[1]), 0);
    wait_clear("R4 bitmap clear");
    acc(0, 8'h28, 0, rd, s); chk("R9 readback", rd, 32'hA5A5_0001);
  endtask

  task automatic t_hold;
    logic [31:0] rd; int s;
    acc(1, 8'h38, 32'hD1, rd, s);
    acc(1, 8'h38, 32'hD2, rd, s);
    chk("R6 write stalled", 32'(s > 0), 1);
    wait_clear("R6 clear");
    chk("R6 second value", slice(4), 32'hD2);
    acc(1, 8'h2c, 32'hCAFE, rd, s);
    acc(0, 8'h2c, 0, rd, s);
    chk("R6 read stalled", 32'(s > 0), 1);
    chk("R9 read after hold", rd, 32'hCAFE);
  endtask

  task automatic t_multi;
    logic [31:0] rd; int s;
    logic [31:0] keep;
    keep = slice(1);
    acc(1, 8'h24, 32'h11, rd, s);
    acc(1, 8'h30, 32'h33, rd, s);
    acc(1, 8'h58, 32'h99, rd, s);
    acc(0, 8'h34, 0, rd, s);
    chk("R10 bitmap", rd, 32'h209);
    wait_clear("R10 clear");
    chk("R10 slice0", slice(0), 32'h11);
    chk("R10 slice3", slice(3), 32'h33);
    chk("R10 slice9", slice(9), 32'h99);
    chk("R10 other slice", slice(1), keep);
  endtask

  task automatic t_untracked;
    logic [31:0] rd; int s;
    logic [319:0] snap;
    snap = f_regs;
    acc(1, 8'h1c, 32'hFFFF_FFFF, rd, s);
    chk("R7 no stall", s, 0);
    acc(0, 8'h34, 0, rd, s);
    chk("R7 no pending", rd, 0);
    repeat (8) @(posedge fclk);
    #1 chk("R7 outputs unchanged", 32'(f_regs != snap), 0);
  endtask

  task automatic t_nonposted;
    logic [31:0] rd; int s;
    acc(1, 8'h40, 32'h0, rd, s);
    acc(0, 8'h40, 0, rd, s); chk("R8 mode off", rd, 0);
    acc(1, 8'h50, 32'h7777, rd, s);
    chk("R8 stalled", 32'(s >= 4), 1);
    chk("R8 value already there", slice(7), 32'h7777);
    acc(0, 8'h34, 0, rd, s); chk("R8 bit clear", rd, 0);
    acc(1, 8'h40, 32'h4, rd, s);
    acc(0, 8'h40, 0, rd, s); chk("R8 mode on", rd, 32'h4);
    acc(1, 8'h48, 32'h55, rd, s);
    chk("R8 posted again", s, 0);
    wait_clear("R8 clear");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1; frst_n = 1;
    t_reset;
    t_map;
    t_posted;
    t_hold;
    t_multi;
    t_untracked;
    t_nonposted;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule